// File: doc/BRIEF.md
# Cluster power state controller

This block keeps the power state of every core and every cluster in a small multi-cluster processor system. Software drives it through five 32-bit word registers on a simple single-cycle register bus. Each command names its target with a 24-bit affinity identifier. Bits 7:0 pick the core within a cluster, bits 15:8 pick the cluster, and bits 23:16 must be zero. Each bus write also carries a sideband identifier for the core that issued it.

A processor-on command powers an off core at once, and it powers that core's cluster on too if needed. Processor-off and cluster-off commands only mark a power-down as pending. The power-down completes the next time the target raises its standby signal. A per-core wake enable lets an external wake request bring a suspended core back. The block records why each core last came up.

Status is read indirectly. Writing an identifier to the status word selects a core, and the next read of that word returns the selected core's power bits and power-on reason. A command that breaks the usage rules changes no state and sets a sticky error output.

Top module: `cluster_pwr_ctrl`

## Requirements
- R1: After `rst`, the following state holds:
  - core 0 of cluster 0 and cluster 0 are on, with reason 00;
  - every other core and cluster is off;
  - all wake enables are clear;
  - `prog_err` is low.
- R2: The registers are selected by byte offset:
  - 0x00 processor-off, 0x04 processor-on, 0x08 cluster-off, 0x0C wake enable, 0x10 status.
  - `rdata` is registered and updates one cycle after `rd_en`.
  - `rdata` is zero in any cycle after one without `rd_en`, and zero for reads of any word other than status.
- R3: A write to the status word latches bits 23:0 as the selector. A status read then returns the selected core's state:
  - bit 31: some cluster is on;
  - bit 30: the selected core's cluster is on;
  - bit 29: the core is on;
  - bit 28: the core's wake enable;
  - bit 27: cluster-off pending;
  - bit 26: core-off pending;
  - bits 25:24: last power-on reason;
  - every other bit is zero, and the whole word is zero when the selector is not a valid identifier.
- R4: A processor-on write that names an off core turns that core on with reason 10. It also turns the core's cluster on if the cluster was off. A core is never on while its cluster is off.
- R5: A processor-off write that names the requester's own core, while that core is on, sets the core's pending bit. The core turns off, and the pending bit clears, in the cycle after its `core_standby` bit is seen high.
- R6: A cluster-off write that names the requester's own cluster, while that cluster is on, sets the cluster's pending bit. When that cluster's `clus_standby` bit is then seen high, the cluster and all of its cores turn off.
- R7: A write to the wake-enable word sets the named core's enable to `wdata[31]`. A write with bit 31 clear disables it.
- R8: A `wake_req` bit turns its off core on only when that core's wake enable is set. It records reason 11 and turns the cluster on if needed. Without the enable the core stays off.
- R9: The following writes are programming errors:
  - processor-on to a core that is already on;
  - processor-off to a core other than the requester's own, or to a core that is off;
  - cluster-off to a cluster other than the requester's own, or to a cluster that is off.
  A programming error leaves every core and cluster state unchanged and sets `prog_err`, which stays set until `rst`.
- R10: In command words, bits 31:24 are ignored, except bit 31 of the wake-enable word. An identifier with bits 23:16 non-zero, or with a cluster or core number out of range, is a programming error on every command word.
- R11: A one-cycle `pin_rst` does the following:
  - core 0 of cluster 0 and cluster 0 end up on with reason 01;
  - all other cores and clusters end up off;
  - all pending bits and wake enables are cleared;
  - other cores keep their last reason;
  - `prog_err` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| pin_rst | input | 1 | Synchronous system reset pin event |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| req_id | input | 24 | Affinity identifier of the writing core |
| rdata | output | 32 | Registered read data |
| core_standby | input | N_CLUS*N_CORE | Per-core standby-for-interrupt |
| clus_standby | input | N_CLUS | Per-cluster standby |
| wake_req | input | N_CLUS*N_CORE | Per-core external wake request |
| core_on | output | N_CLUS*N_CORE | Core power state, index cluster*N_CORE+core |
| clus_on | output | N_CLUS | Cluster power state |
| prog_err | output | 1 | Sticky programming error |

## Verification
The checker assumes a few things about the inputs:
- a wake request is only judged in cycles with no bus write and no pin reset;
- standby is only judged when no pin reset is present;
- bus reads are back to back only when the strobe sequence says so.

The bench keeps within these limits. It drives one bus access at a time on the falling edge, and it pulses standby, wake and pin-reset inputs for a single cycle, never in a cycle that carries a write. Every scenario that needs a clean start begins with a cold reset, so the sticky error from one case never masks the next.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int AFF_W = 24;
  localparam int DW    = 32;
  // word indices (byte offset / 4)
  localparam int W_POFF = 0;
  localparam int W_PON  = 1;
  localparam int W_COFF = 2;
  localparam int W_WEN  = 3;
  localparam int W_STAT = 4;
  // status word bit positions
  localparam int S_ANY  = 31;
  localparam int S_CLUS = 30;
  localparam int S_CORE = 29;
  localparam int S_WEN  = 28;
  localparam int S_PC   = 27;
  localparam int S_PP   = 26;
  localparam int S_RSN  = 24;
  localparam int WEN_BIT = 31;

  typedef enum logic [1:0] {
    RSN_COLD = 2'b00,
    RSN_PIN  = 2'b01,
    RSN_CMD  = 2'b10,
    RSN_WAKE = 2'b11
  } rsn_e;
endpackage

// File: rtl/cpc_aff_dec.sv
module cpc_aff_dec #(
  parameter int N_CLUS = 2,
  parameter int N_CORE = 2,
  parameter int CL_W   = 1,
  parameter int IDX_W  = 2
) (
  input  logic [23:0]      id,
  output logic             ok,
  output logic [CL_W-1:0]  cl,
  output logic [IDX_W-1:0] flat
);
  logic [7:0] a0, a1, a2;

  always_comb begin
    a0   = id[7:0];
    a1   = id[15:8];
    a2   = id[23:16];
    ok   = (a2 == 8'd0) && (int'(a1) < N_CLUS) && (int'(a0) < N_CORE);
    cl   = a1[CL_W-1:0];
    flat = IDX_W'(int'(a1) * N_CORE + int'(a0));
  end
endmodule

// File: rtl/cpc_core_slot.sv
module cpc_core_slot
  import cpc_pkg::*;
#(
  parameter bit BOOT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_rst,
  input  logic on_cmd,
  input  logic off_cmd,
  input  logic wen_wr,
  input  logic wen_val,
  input  logic standby,
  input  logic wake,
  input  logic clus_down,
  output logic on,
  output logic pend,
  output logic wen,
  output rsn_e rsn,
  output logic up
);
  // the core comes up this cycle (cluster power-down wins)
  always_comb up = !clus_down && !on && (on_cmd || (wake && wen));

  always_ff @(posedge clk) begin
    if (rst) begin
      on   <= BOOT;
      pend <= 1'b0;
      wen  <= 1'b0;
      rsn  <= RSN_COLD;
    end else if (pin_rst) begin
      on   <= BOOT;
      pend <= 1'b0;
      wen  <= 1'b0;
      if (BOOT) rsn <= RSN_PIN;
    end else begin
      if (wen_wr) wen <= wen_val;
      if (clus_down || (pend && standby)) begin
        on   <= 1'b0;
        pend <= 1'b0;
      end else if (up) begin
        on  <= 1'b1;
        rsn <= on_cmd ? RSN_CMD : RSN_WAKE;
      end else if (off_cmd) begin
        pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpc_clus_slot.sv
module cpc_clus_slot #(
  parameter bit BOOT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_rst,
  input  logic up,
  input  logic off_cmd,
  input  logic standby,
  output logic on,
  output logic pend,
  output logic down
);
  always_comb down = pend && standby;

  always_ff @(posedge clk) begin
    if (rst || pin_rst) begin
      on   <= BOOT;
      pend <= 1'b0;
    end else if (down) begin
      on   <= 1'b0;
      pend <= 1'b0;
    end else if (up) begin
      on   <= 1'b1;
      pend <= 1'b0;
    end else if (off_cmd) begin
      pend <= 1'b1;
    end
  end
endmodule

// File: rtl/cluster_pwr_ctrl.sv
module cluster_pwr_ctrl
  import cpc_pkg::*;
#(
  parameter  int N_CLUS = 2,
  parameter  int N_CORE = 2,
  parameter  int ADDR_W = 5,
  localparam int NCT    = N_CLUS * N_CORE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [23:0]       req_id,
  output logic [31:0]       rdata,
  input  logic [NCT-1:0]    core_standby,
  input  logic [N_CLUS-1:0] clus_standby,
  input  logic [NCT-1:0]    wake_req,
  output logic [NCT-1:0]    core_on,
  output logic [N_CLUS-1:0] clus_on,
  output logic              prog_err
);
  localparam int CL_W  = (N_CLUS > 1) ? $clog2(N_CLUS) : 1;
  localparam int IDX_W = (NCT > 1) ? $clog2(NCT) : 1;
  localparam int WRD_W = ADDR_W - 2;

  logic [WRD_W-1:0] word;
  logic             wr_poff, wr_pon, wr_coff, wr_wen, wr_stat;
  logic             t_ok, r_ok, s_ok, err;
  logic [CL_W-1:0]  t_cl, r_cl, s_cl;
  logic [IDX_W-1:0] t_flat, r_flat, s_flat;
  logic [23:0]      sel;
  logic [31:0]      stat;

  logic [NCT-1:0]    c_on, c_pend, c_wen, c_up;
  rsn_e              c_rsn [NCT];
  logic [N_CLUS-1:0] k_on, k_pend, k_down, k_up;

  logic unused_bits;
  assign unused_bits = ^{addr[1:0], wdata[30:24]};

  assign word    = addr[ADDR_W-1:2];
  assign wr_poff = wr_en && (word == WRD_W'(W_POFF));
  assign wr_pon  = wr_en && (word == WRD_W'(W_PON));
  assign wr_coff = wr_en && (word == WRD_W'(W_COFF));
  assign wr_wen  = wr_en && (word == WRD_W'(W_WEN));
  assign wr_stat = wr_en && (word == WRD_W'(W_STAT));

  cpc_aff_dec #(.N_CLUS(N_CLUS), .N_CORE(N_CORE), .CL_W(CL_W), .IDX_W(IDX_W))
    u_tgt (.id(wdata[23:0]), .ok(t_ok), .cl(t_cl), .flat(t_flat));
  cpc_aff_dec #(.N_CLUS(N_CLUS), .N_CORE(N_CORE), .CL_W(CL_W), .IDX_W(IDX_W))
    u_req (.id(req_id), .ok(r_ok), .cl(r_cl), .flat(r_flat));
  cpc_aff_dec #(.N_CLUS(N_CLUS), .N_CORE(N_CORE), .CL_W(CL_W), .IDX_W(IDX_W))
    u_sel (.id(sel), .ok(s_ok), .cl(s_cl), .flat(s_flat));

  // usage-rule check for the write in flight
  always_comb begin
    err = 1'b0;
    if (wr_poff)
      err = !t_ok || !r_ok || (t_flat != r_flat) || !c_on[t_flat] || c_pend[t_flat];
    else if (wr_pon)
      err = !t_ok || c_on[t_flat];
    else if (wr_coff)
      err = !t_ok || !r_ok || (t_cl != r_cl) || !k_on[t_cl];
    else if (wr_wen)
      err = !t_ok;
  end

  for (genvar g = 0; g < NCT; g++) begin : g_core
    logic hit;
    assign hit = !err && t_ok && (t_flat == IDX_W'(g));
    cpc_core_slot #(.BOOT(g == 0)) u_core (
      .clk(clk), .rst(rst), .pin_rst(pin_rst),
      .on_cmd(wr_pon && hit), .off_cmd(wr_poff && hit),
      .wen_wr(wr_wen && hit), .wen_val(wdata[WEN_BIT]),
      .standby(core_standby[g]), .wake(wake_req[g]),
      .clus_down(k_down[g / N_CORE]),
      .on(c_on[g]), .pend(c_pend[g]), .wen(c_wen[g]), .rsn(c_rsn[g]), .up(c_up[g])
    );
  end

  for (genvar k = 0; k < N_CLUS; k++) begin : g_clus
    assign k_up[k] = |c_up[k*N_CORE +: N_CORE];
    cpc_clus_slot #(.BOOT(k == 0)) u_clus (
      .clk(clk), .rst(rst), .pin_rst(pin_rst),
      .up(k_up[k]),
      .off_cmd(wr_coff && !err && (t_cl == CL_W'(k))),
      .standby(clus_standby[k]),
      .on(k_on[k]), .pend(k_pend[k]), .down(k_down[k])
    );
  end

  always_comb begin
    stat         = '0;
    stat[S_ANY]  = |k_on;
    stat[S_CLUS] = k_on[s_cl];
    stat[S_CORE] = c_on[s_flat];
    stat[S_WEN]  = c_wen[s_flat];
    stat[S_PC]   = k_pend[s_cl];
    stat[S_PP]   = c_pend[s_flat];
    stat[S_RSN +: 2] = c_rsn[s_flat];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel      <= '0;
      rdata    <= '0;
      prog_err <= 1'b0;
    end else begin
      if (wr_stat) sel <= wdata[23:0];
      rdata <= (rd_en && (word == WRD_W'(W_STAT)) && s_ok) ? stat : '0;
      if (err) prog_err <= 1'b1;
    end
  end

  assign core_on = c_on;
  assign clus_on = k_on;
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
  parameter  int N_CLUS = 2,
  parameter  int N_CORE = 2,
  localparam int NCT    = N_CLUS * N_CORE
) (
  input logic              clk,
  input logic              rst,
  input logic              pin_rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [NCT-1:0]    wake_req,
  input logic [NCT-1:0]    core_standby,
  input logic [NCT-1:0]    core_on,
  input logic [NCT-1:0]    core_pend,
  input logic [NCT-1:0]    core_wen,
  input logic [N_CLUS-1:0] clus_on,
  input logic              prog_err,
  input logic [31:0]       rdata
);
  for (genvar g = 0; g < NCT; g++) begin : g_chk
    p_core_in_live_clus_r4: assert property (@(posedge clk) disable iff (rst)
      core_on[g] |-> clus_on[g / N_CORE]);
    p_pend_needs_on_r5: assert property (@(posedge clk) disable iff (rst)
      core_pend[g] |-> core_on[g]);
    p_standby_ends_pend_r5: assert property (@(posedge clk) disable iff (rst)
      (core_pend[g] && core_standby[g] && !pin_rst) |=> !core_on[g]);
    p_wake_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
      (!core_on[g] && !core_wen[g] && wake_req[g] && !wr_en && !pin_rst) |=> !core_on[g]);
  end

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    prog_err |=> prog_err);
  p_idle_rdata_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == 32'd0));
endmodule

bind cluster_pwr_ctrl cpc_checker #(.N_CLUS(N_CLUS), .N_CORE(N_CORE)) u_chk (
  .clk(clk), .rst(rst), .pin_rst(pin_rst), .wr_en(wr_en), .rd_en(rd_en),
  .wake_req(wake_req), .core_standby(core_standby), .core_on(core_on),
  .core_pend(c_pend), .core_wen(c_wen), .clus_on(clus_on),
  .prog_err(prog_err), .rdata(rdata)
);

// File: tb/cluster_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module cluster_pwr_ctrl_bench;
  localparam logic [4:0] A_POFF = 5'h00, A_PON = 5'h04, A_COFF = 5'h08,
                         A_WEN = 5'h0C, A_STAT = 5'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [23:0] req_id = '0;
  logic [31:0] rdata;
  logic [3:0]  core_standby = '0;
  logic [1:0]  clus_standby = '0;
  logic [3:0]  wake_req = '0;
  logic [3:0]  core_on;
  logic [1:0]  clus_on;
  logic        prog_err;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cluster_pwr_ctrl u_cluster_pwr_ctrl (
    .clk(clk), .rst(rst), .pin_rst(pin_rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .req_id(req_id), .rdata(rdata),
    .core_standby(core_standby), .clus_standby(clus_standby), .wake_req(wake_req),
    .core_on(core_on), .clus_on(clus_on), .prog_err(prog_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sw(input bit any, input bit cl, input bit co, input bit en,
                                     input bit pc, input bit pp, input logic [1:0] rs);
    return {any, cl, co, en, pc, pp, rs, 24'h0};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [31:0] d, input logic [23:0] rq);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d; req_id = rq;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic stat(input logic [23:0] id, output logic [31:0] v);
    do_wr(A_STAT, {8'h0, id}, 24'h0);
    do_rd(A_STAT, v);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    chk("R1 core_on", {28'h0, core_on}, 32'h1);
    chk("R1 clus_on", {30'h0, clus_on}, 32'h1);
    chk("R1 prog_err", {31'h0, prog_err}, 32'h0);
    stat(24'h000000, v); chk("R1 R3 status core0", v, sw(1,1,1,0,0,0,2'b00));
    stat(24'h000001, v); chk("R1 R3 status core1", v, sw(1,1,0,0,0,0,2'b00));
    stat(24'h000101, v); chk("R1 R3 status c1 core1", v, sw(1,0,0,0,0,0,2'b00));
    stat(24'h000003, v); chk("R3 invalid selector", v, 32'h0);
  endtask

  task automatic t_bus();
    logic [31:0] v;
    do_reset();
    do_rd(A_PON, v); chk("R2 non-status read", v, 32'h0);
    stat(24'h000000, v); chk("R2 status read", v, sw(1,1,1,0,0,0,2'b00));
    @(negedge clk); chk("R2 idle rdata", rdata, 32'h0);
  endtask

  task automatic t_on_off();
    logic [31:0] v;
    do_reset();
    do_wr(A_PON, 32'h7F00_0101, 24'h0);
    chk("R4 R10 core_on", {28'h0, core_on}, 32'h9);
    chk("R4 clus_on", {30'h0, clus_on}, 32'h3);
    chk("R10 no error", {31'h0, prog_err}, 32'h0);
    stat(24'h000101, v); chk("R4 status", v, sw(1,1,1,0,0,0,2'b10));
    do_wr(A_POFF, 32'h0000_0101, 24'h000101);
    stat(24'h000101, v); chk("R5 pending", v, sw(1,1,1,0,0,1,2'b10));
    chk("R5 still on", {28'h0, core_on}, 32'h9);
    @(negedge clk); core_standby[3] = 1'b1;
    @(negedge clk); core_standby[3] = 1'b0;
    chk("R5 off after standby", {28'h0, core_on}, 32'h1);
    stat(24'h000101, v); chk("R5 status off", v, sw(1,1,0,0,0,0,2'b10));
  endtask

  task automatic t_clus_off();
    logic [31:0] v;
    do_reset();
    do_wr(A_PON, 32'h0000_0100, 24'h0);
    do_wr(A_COFF, 32'h0000_0100, 24'h000100);
    stat(24'h000100, v); chk("R6 pending", v, sw(1,1,1,0,1,0,2'b10));
    @(negedge clk); clus_standby[1] = 1'b1;
    @(negedge clk); clus_standby[1] = 1'b0;
    chk("R6 clus_on", {30'h0, clus_on}, 32'h1);
    chk("R6 core_on", {28'h0, core_on}, 32'h1);
    stat(24'h000100, v); chk("R6 status", v, sw(1,0,0,0,0,0,2'b10));
  endtask

  task automatic t_wake();
    logic [31:0] v;
    do_reset();
    @(negedge clk); wake_req[1] = 1'b1;
    @(negedge clk); wake_req[1] = 1'b0;
    chk("R8 wake without enable", {28'h0, core_on}, 32'h1);
    do_wr(A_WEN, 32'h8000_0001, 24'h0);
    stat(24'h000001, v); chk("R7 enable set", v, sw(1,1,0,1,0,0,2'b00));
    @(negedge clk); wake_req[1] = 1'b1;
    @(negedge clk); wake_req[1] = 1'b0;
    chk("R8 woken", {28'h0, core_on}, 32'h3);
    stat(24'h000001, v); chk("R8 reason 11", v, sw(1,1,1,1,0,0,2'b11));
    do_wr(A_WEN, 32'h0000_0001, 24'h0);
    stat(24'h000001, v); chk("R7 enable clear", v, sw(1,1,1,0,0,0,2'b11));
    do_wr(A_WEN, 32'h8000_0101, 24'h0);
    @(negedge clk); wake_req[3] = 1'b1;
    @(negedge clk); wake_req[3] = 1'b0;
    chk("R8 cluster up", {30'h0, clus_on}, 32'h3);
    stat(24'h000101, v); chk("R8 status c1", v, sw(1,1,1,1,0,0,2'b11));
  endtask

  task automatic t_errors();
    logic [31:0] v;
    do_reset();
    do_wr(A_PON, 32'h0000_0000, 24'h0);
    chk("R9 on-to-on error", {31'h0, prog_err}, 32'h1);
    chk("R9 on-to-on state", {28'h0, core_on}, 32'h1);
    do_reset();
    do_wr(A_PON, 32'h0000_0001, 24'h0);
    do_wr(A_POFF, 32'h0000_0001, 24'h000000);
    chk("R9 foreign off error", {31'h0, prog_err}, 32'h1);
    stat(24'h000001, v); chk("R9 foreign off state", v, sw(1,1,1,0,0,0,2'b10));
    do_reset();
    do_wr(A_PON, 32'h0000_0100, 24'h0);
    do_wr(A_COFF, 32'h0000_0100, 24'h000000);
    chk("R9 foreign cluster error", {31'h0, prog_err}, 32'h1);
    stat(24'h000100, v); chk("R9 foreign cluster state", v, sw(1,1,1,0,0,0,2'b10));
    do_reset();
    do_wr(A_PON, 32'h0000_0002, 24'h0);
    chk("R10 core range error", {31'h0, prog_err}, 32'h1);
    chk("R10 core range state", {28'h0, core_on}, 32'h1);
    do_reset();
    do_wr(A_PON, 32'h0001_0001, 24'h0);
    chk("R10 aff2 error", {31'h0, prog_err}, 32'h1);
    chk("R10 aff2 state", {28'h0, core_on}, 32'h1);
  endtask

  task automatic t_pin();
    logic [31:0] v;
    do_reset();
    do_wr(A_PON, 32'h0000_0101, 24'h0);
    do_wr(A_WEN, 32'h8000_0000, 24'h0);
    do_wr(A_PON, 32'h0000_0000, 24'h0);
    @(negedge clk); pin_rst = 1'b1;
    @(negedge clk); pin_rst = 1'b0;
    chk("R11 core_on", {28'h0, core_on}, 32'h1);
    chk("R11 clus_on", {30'h0, clus_on}, 32'h1);
    chk("R11 error kept", {31'h0, prog_err}, 32'h1);
    stat(24'h000000, v); chk("R11 core0", v, sw(1,1,1,0,0,0,2'b01));
    stat(24'h000101, v); chk("R11 other reason kept", v, sw(1,0,0,0,0,0,2'b10));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_bus();
    t_on_off();
    t_clus_off();
    t_wake();
    t_errors();
    t_pin();
    summary();
  end
endmodule